// File: doc/BRIEF.md
# Packet Router with Channel Buffers

This block sits behind a packet-oriented host link. The host side writes 16-bit words into an ingress buffer on its own bus clock. Those words form a stream of fixed-length packets. In the core clock domain, a single router takes each complete packet from that buffer and copies it unchanged into one of several destinations. A packet can go to one channel sample buffer or to the one shared control buffer. Each destination is read out by its own consumer, at its own pace.

The first word of every packet is a header. Bit 15 of the header marks the packet as control. When bit 15 is clear, bits [4:0] give the channel number. The router moves a packet only as a whole. It begins a transfer only when every word of the packet has reached the ingress buffer and the destination has room for a full packet. Once a transfer has started, it moves one word per core clock. A packet whose channel number was not built is consumed and discarded, and a drop counter is incremented.

Word pointers cross the clock boundary in Gray code through two-flop synchronizers. The ingress buffer is the only structure that has two clocks.

Top module: `pkt_router`

## Requirements
- R1: After reset, every channel buffer and the control buffer report empty, `drop_count_o` is 0 and `bus_full_o` is low.
- R2: A packet whose header has bit 15 set is delivered to the control buffer as all of its words (header included), in arrival order.
- R3: A packet whose header has bit 15 clear and bits [4:0] below N_CH is delivered whole, header included and in order, to channel buffer number bits [4:0]. No other buffer receives any of its words.
- R4: A packet whose header has bit 15 clear and bits [4:0] at or above N_CH is discarded whole. `drop_count_o` rises by exactly 1, no buffer receives any word, and the next packet is still routed correctly.
- R5: Packets for different channels may arrive in any interleaving. Each channel receives its own packets in arrival order, and the words of two packets are never mixed in one transfer.
- R6: No transfer starts until all PKT_WORDS words of the head packet are in the ingress buffer. A packet with one word missing leaves every output buffer empty.
- R7: The router never writes into a full buffer. When the destination lacks room for PKT_WORDS words, the packet waits in the ingress buffer and is delivered complete once room appears.
- R8: A channel whose buffer is full and unread does not prevent packets already routed to other channels from being read out.
- R9: Once a transfer has started, it moves one word per core clock, so a packet takes PKT_WORDS consecutive cycles.
- R10: A set bit 15 takes priority over the channel field. A control packet whose bits [4:0] equal 31 goes to the control buffer and is not counted as a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Host bus clock (ingress write side) |
| bus_rst_ni | input | 1 | Active-low async reset, bus domain |
| bus_wr_en_i | input | 1 | Ingress word write strobe |
| bus_wr_data_i | input | W | Ingress word |
| bus_full_o | output | 1 | Ingress buffer full; writes ignored |
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low async reset, core domain |
| ch_rd_en_i | input | N_CH | Per-channel pop strobe |
| ch_rd_data_o | output | N_CH*W | Per-channel head word, channel i at bits [i*W +: W] |
| ch_empty_o | output | N_CH | Per-channel empty flag |
| ctrl_rd_en_i | input | 1 | Control buffer pop strobe |
| ctrl_rd_data_o | output | W | Control buffer head word |
| ctrl_empty_o | output | 1 | Control buffer empty flag |
| drop_count_o | output | DROP_W | Number of discarded packets |

## Verification
The bound checker evaluates several properties on every core clock:

- No destination is written while it is full.
- At most one destination is written in a cycle.
- The destination does not change within a run of writes.
- Every write run lasts exactly one packet length.
- Every write pairs with an ingress read, and no read happens from an empty ingress buffer.
- The drop counter moves only in single steps.

Some behaviours can only be shown by the bench's scenarios. These are:

- correct decoding of the header into a destination;
- ordering across interleaved channels;
- holding back a partial packet;
- a waiting packet being released once a stalled channel is read;
- the absence of reader stalls that proves one-word-per-cycle throughput.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MOVE,
    ST_DROP
  } route_st_e;

  // header word layout
  localparam int HDR_CTRL_BIT = 15;
  localparam int HDR_CH_LSB   = 0;
  localparam int HDR_CH_W     = 5;
endpackage

// File: rtl/pkt_cdc_fifo.sv
module pkt_cdc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          full_o,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          rd_en_i,
  output logic [W-1:0]  rd_data_o,
  output logic          empty_o,
  output logic [PW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rg_s1_q, rg_s2_q, wg_s1_q, wg_s2_q;
  logic [PW-1:0] wbin_sync, wbin_nxt, rbin_nxt;
  logic          push, pop;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  assign full_o   = (wgray_q == {~rg_s2_q[PW-1:PW-2], rg_s2_q[PW-3:0]});
  assign push     = wr_en_i & ~full_o;
  assign wbin_nxt = wbin_q + 1'b1;

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1_q <= '0;
      rg_s2_q <= '0;
    end else begin
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
      if (push) begin
        wbin_q  <= wbin_nxt;
        wgray_q <= to_gray(wbin_nxt);
      end
    end
  end

  always_ff @(posedge wclk_i) begin
    if (push) mem[wbin_q[AW-1:0]] <= wr_data_i;
  end

  // read domain
  assign wbin_sync = from_gray(wg_s2_q);
  assign count_o   = wbin_sync - rbin_q;
  assign empty_o   = (count_o == '0);
  assign pop       = rd_en_i & ~empty_o;
  assign rbin_nxt  = rbin_q + 1'b1;
  assign rd_data_o = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1_q <= '0;
      wg_s2_q <= '0;
    end else begin
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
      if (pop) begin
        rbin_q  <= rbin_nxt;
        rgray_q <= to_gray(rbin_nxt);
      end
    end
  end
endmodule

// File: rtl/pkt_buf_fifo.sv
module pkt_buf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 512,
  parameter int BLK   = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         room_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ROOM_LIM = CW'(DEPTH - BLK);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == FULL_CNT);
  assign room_o    = (cnt_q <= ROOM_LIM);
  assign push      = wr_en_i & ~full_o;
  assign pop       = rd_en_i & ~empty_o;
  assign rd_data_o = mem[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr_q] <= wr_data_i;
  end
endmodule

// File: rtl/pkt_route_ctrl.sv
module pkt_route_ctrl
  import pkt_router_pkg::*;
#(
  parameter int W         = 16,
  parameter int N_CH      = 4,
  parameter int PKT_WORDS = 256,
  parameter int CNT_W     = 10,
  parameter int DROP_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      head_i,
  input  logic [CNT_W-1:0]  avail_i,
  input  logic [N_CH:0]     room_i,
  output logic              pop_o,
  output logic [N_CH:0]     push_o,
  output logic [DROP_W-1:0] drop_count_o
);
  localparam int PIW                  = $clog2(PKT_WORDS);
  localparam logic [CNT_W-1:0] PKT_CNT = CNT_W'(PKT_WORDS);
  localparam logic [PIW-1:0] LAST_IDX  = PIW'(PKT_WORDS - 1);

  route_st_e          st_q, st_d;
  logic [N_CH:0]      sel_q, sel_d, tgt;
  logic [PIW-1:0]     idx_q, idx_d;
  logic [DROP_W-1:0]  drop_q, drop_d;
  logic [HDR_CH_W-1:0] ch_f;
  logic               pkt_ready, bad_ch;

  assign ch_f         = head_i[HDR_CH_LSB +: HDR_CH_W];
  assign pkt_ready    = (avail_i >= PKT_CNT);
  assign drop_count_o = drop_q;

  // header decode: control flag wins over channel field
  always_comb begin
    tgt    = '0;
    bad_ch = 1'b1;
    if (head_i[HDR_CTRL_BIT]) begin
      tgt[N_CH] = 1'b1;
      bad_ch    = 1'b0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (ch_f == HDR_CH_W'(i)) begin
          tgt[i] = 1'b1;
          bad_ch = 1'b0;
        end
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    drop_d = drop_q;
    pop_o  = 1'b0;
    push_o = '0;
    case (st_q)
      ST_IDLE: begin
        if (pkt_ready) begin
          idx_d = '0;
          if (bad_ch) begin
            st_d = ST_DROP;
          end else if (|(tgt & room_i)) begin
            st_d  = ST_MOVE;
            sel_d = tgt;
          end
        end
      end
      ST_MOVE: begin
        pop_o  = 1'b1;
        push_o = sel_q;
        idx_d  = idx_q + 1'b1;
        if (idx_q == LAST_IDX) st_d = ST_IDLE;
      end
      ST_DROP: begin
        pop_o = 1'b1;
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          st_d   = ST_IDLE;
          drop_d = drop_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      idx_q  <= '0;
      drop_q <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      idx_q  <= idx_d;
      drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/pkt_router.sv
module pkt_router #(
  parameter int W         = 16,
  parameter int N_CH      = 4,
  parameter int PKT_WORDS = 256,
  parameter int ING_PKTS  = 2,
  parameter int CH_PKTS   = 2,
  parameter int CTRL_PKTS = 2,
  parameter int DROP_W    = 16
) (
  input  logic              bus_clk_i,
  input  logic              bus_rst_ni,
  input  logic              bus_wr_en_i,
  input  logic [W-1:0]      bus_wr_data_i,
  output logic              bus_full_o,
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   ch_rd_en_i,
  output logic [N_CH*W-1:0] ch_rd_data_o,
  output logic [N_CH-1:0]   ch_empty_o,
  input  logic              ctrl_rd_en_i,
  output logic [W-1:0]      ctrl_rd_data_o,
  output logic              ctrl_empty_o,
  output logic [DROP_W-1:0] drop_count_o
);
  localparam int ING_DEPTH  = ING_PKTS * PKT_WORDS;
  localparam int CH_DEPTH   = CH_PKTS * PKT_WORDS;
  localparam int CTRL_DEPTH = CTRL_PKTS * PKT_WORDS;
  localparam int ING_CW     = $clog2(ING_DEPTH) + 1;

  logic [W-1:0]      ing_data;
  logic [ING_CW-1:0] ing_count;
  logic              ing_empty, ing_pop;
  logic [N_CH:0]     dst_push, dst_room, dst_full, dst_empty, dst_rd;
  logic [W-1:0]      dst_data [N_CH+1];

  pkt_cdc_fifo #(.W(W), .DEPTH(ING_DEPTH)) u_ingress (
    .wclk_i   (bus_clk_i),
    .wrst_ni  (bus_rst_ni),
    .wr_en_i  (bus_wr_en_i),
    .wr_data_i(bus_wr_data_i),
    .full_o   (bus_full_o),
    .rclk_i   (clk_i),
    .rrst_ni  (rst_ni),
    .rd_en_i  (ing_pop),
    .rd_data_o(ing_data),
    .empty_o  (ing_empty),
    .count_o  (ing_count)
  );

  pkt_route_ctrl #(
    .W(W), .N_CH(N_CH), .PKT_WORDS(PKT_WORDS), .CNT_W(ING_CW), .DROP_W(DROP_W)
  ) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_i      (ing_data),
    .avail_i     (ing_count),
    .room_i      (dst_room),
    .pop_o       (ing_pop),
    .push_o      (dst_push),
    .drop_count_o(drop_count_o)
  );

  // index N_CH is the control buffer, the rest are channels
  for (genvar g = 0; g <= N_CH; g++) begin : g_dst
    localparam int DEP = (g == N_CH) ? CTRL_DEPTH : CH_DEPTH;
    pkt_buf_fifo #(.W(W), .DEPTH(DEP), .BLK(PKT_WORDS)) u_buf (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (dst_push[g]),
      .wr_data_i(ing_data),
      .rd_en_i  (dst_rd[g]),
      .rd_data_o(dst_data[g]),
      .empty_o  (dst_empty[g]),
      .full_o   (dst_full[g]),
      .room_o   (dst_room[g])
    );
    if (g == N_CH) begin : g_ctrl
      assign dst_rd[g]      = ctrl_rd_en_i;
      assign ctrl_rd_data_o = dst_data[g];
      assign ctrl_empty_o   = dst_empty[g];
    end else begin : g_ch
      assign dst_rd[g]             = ch_rd_en_i[g];
      assign ch_rd_data_o[g*W +: W] = dst_data[g];
      assign ch_empty_o[g]         = dst_empty[g];
    end
  end
endmodule

// File: rtl/pkt_router_chk.sv
module pkt_router_chk #(
  parameter int N_CH      = 4,
  parameter int PKT_WORDS = 256,
  parameter int DROP_W    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CH:0]     dst_push,
  input logic [N_CH:0]     dst_full,
  input logic              ing_pop,
  input logic              ing_empty,
  input logic [DROP_W-1:0] drop_count
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (|dst_push) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_push & dst_full) == '0);

  a_r5_one_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dst_push));

  a_r5_dest_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|dst_push) && $past(|dst_push)) |-> (dst_push == $past(dst_push)));

  a_r9_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|dst_push) |-> (run_q == 32'(PKT_WORDS)));

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ing_pop |-> !ing_empty);

  a_r3_push_with_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dst_push) |-> ing_pop);

  a_r4_drop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));
endmodule

bind pkt_router pkt_router_chk #(
  .N_CH(N_CH), .PKT_WORDS(PKT_WORDS), .DROP_W(DROP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dst_push  (dst_push),
  .dst_full  (dst_full),
  .ing_pop   (ing_pop),
  .ing_empty (ing_empty),
  .drop_count(drop_count_o)
);

// File: tb/pkt_router_test.sv
module pkt_router_test;
  localparam int W    = 16;
  localparam int N_CH = 4;
  localparam int PKT  = 256;
  localparam int NV   = 9;
  localparam int DROP = 7;

  // header, destination (0..N_CH-1 channel, N_CH control, DROP discard)
  localparam logic [15:0] VEC_HDR [NV] = '{16'h0000, 16'h0003, 16'h8000, 16'h0002,
                                           16'h0009, 16'h801F, 16'h0001, 16'h0004, 16'h001F};
  localparam int VEC_DST [NV] = '{0, 3, 4, 2, DROP, 4, 1, DROP, DROP};

  logic clk = 1'b0, bus_clk = 1'b0;
  logic rst_n = 1'b0, bus_rst_n = 1'b0;
  logic bus_wr_en = 1'b0;
  logic [W-1:0] bus_wr_data = '0;
  logic bus_full;
  logic [N_CH-1:0] ch_rd_en = '0;
  logic [N_CH*W-1:0] ch_rd_data;
  logic [N_CH-1:0] ch_empty;
  logic ctrl_rd_en = 1'b0;
  logic [W-1:0] ctrl_rd_data;
  logic ctrl_empty;
  logic [15:0] drop_count;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always #3.5 bus_clk = ~bus_clk;

  pkt_router uut (
    .bus_clk_i(bus_clk), .bus_rst_ni(bus_rst_n), .bus_wr_en_i(bus_wr_en),
    .bus_wr_data_i(bus_wr_data), .bus_full_o(bus_full),
    .clk_i(clk), .rst_ni(rst_n),
    .ch_rd_en_i(ch_rd_en), .ch_rd_data_o(ch_rd_data), .ch_empty_o(ch_empty),
    .ctrl_rd_en_i(ctrl_rd_en), .ctrl_rd_data_o(ctrl_rd_data), .ctrl_empty_o(ctrl_empty),
    .drop_count_o(drop_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pkt_word(input logic [15:0] hdr, input int id, input int k);
    if (k == 0) return hdr;
    return {1'b0, 7'(id), 8'(k)};
  endfunction

  function automatic logic sel_empty(input int sel);
    return (sel < N_CH) ? ch_empty[sel] : ctrl_empty;
  endfunction

  function automatic logic [W-1:0] sel_data(input int sel);
    return (sel < N_CH) ? ch_rd_data[sel*W +: W] : ctrl_rd_data;
  endfunction

  function automatic logic all_empty();
    return (&ch_empty) & ctrl_empty;
  endfunction

  task automatic send_words(input logic [15:0] hdr, input int id, input int lo, input int hi);
    for (int k = lo; k <= hi; k++) begin
      @(negedge bus_clk);
      while (bus_full) @(negedge bus_clk);
      bus_wr_en   = 1'b1;
      bus_wr_data = pkt_word(hdr, id, k);
      @(posedge bus_clk);
    end
    @(negedge bus_clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic send_pkt(input logic [15:0] hdr, input int id);
    send_words(hdr, id, 0, PKT - 1);
  endtask

  task automatic read_pkt(input int sel, input logic [15:0] hdr, input int id,
                          input string req, output int stalls);
    int bad = 0, fa = 0, fe = 0;
    stalls = 0;
    for (int k = 0; k < PKT; k++) begin
      @(negedge clk);
      ch_rd_en   = '0;
      ctrl_rd_en = 1'b0;
      while (sel_empty(sel)) begin
        if (k > 0) stalls++;
        @(negedge clk);
      end
      if (sel_data(sel) !== pkt_word(hdr, id, k)) begin
        if (bad == 0) begin
          fa = int'(sel_data(sel));
          fe = int'(pkt_word(hdr, id, k));
        end
        bad++;
      end
      if (sel < N_CH) ch_rd_en[sel] = 1'b1;
      else ctrl_rd_en = 1'b1;
    end
    @(negedge clk);
    ch_rd_en   = '0;
    ctrl_rd_en = 1'b0;
    check(bad == 0, req, $sformatf("packet id %0d to dest %0d", id, sel), fa, fe);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int st;
    int exp_drop = 0;
    string req;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    bus_rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(all_empty(), "R1", "buffers empty", int'({ch_empty, ctrl_empty}), 5'h1F);
    check(drop_count == 0, "R1", "drop count", int'(drop_count), 0);
    check(!bus_full, "R1", "bus full", int'(bus_full), 0);

    // table of headers and their destinations
    for (int i = 0; i < NV; i++) begin
      send_pkt(VEC_HDR[i], i);
      if (VEC_DST[i] == DROP) begin
        req = "R4";
        exp_drop++;
        repeat (700) @(negedge clk);
        check(drop_count == 16'(exp_drop), req, "drop count", int'(drop_count), exp_drop);
      end else begin
        if (VEC_DST[i] == N_CH) req = (VEC_HDR[i][4:0] >= N_CH) ? "R10" : "R2";
        else req = "R3";
        read_pkt(VEC_DST[i], VEC_HDR[i], i, req, st);
        if (VEC_DST[i] == N_CH && VEC_HDR[i][4:0] >= N_CH)
          check(drop_count == 16'(exp_drop), "R10", "no drop on control", int'(drop_count), exp_drop);
      end
      check(all_empty(), req, "no stray words", int'({ch_empty, ctrl_empty}), 5'h1F);
    end

    // R6: partial packet is held back
    send_words(16'h0001, 20, 0, PKT - 2);
    repeat (600) @(negedge clk);
    check(all_empty(), "R6", "partial held", int'({ch_empty, ctrl_empty}), 5'h1F);
    send_words(16'h0001, 20, PKT - 1, PKT - 1);
    read_pkt(1, 16'h0001, 20, "R6", st);

    // R9: a fresh packet streams with no reader stall
    send_pkt(16'h0003, 25);
    read_pkt(3, 16'h0003, 25, "R9", st);
    check(st == 0, "R9", "reader stalls", st, 0);

    // R5: interleaved channels
    send_pkt(16'h0001, 30);
    send_pkt(16'h0002, 31);
    send_pkt(16'h0001, 32);
    send_pkt(16'h0002, 33);
    read_pkt(2, 16'h0002, 31, "R5", st);
    read_pkt(2, 16'h0002, 33, "R5", st);
    read_pkt(1, 16'h0001, 30, "R5", st);
    read_pkt(1, 16'h0001, 32, "R5", st);
    check(all_empty(), "R5", "no stray words", int'({ch_empty, ctrl_empty}), 5'h1F);

    // R7/R8: ch0 fills, a third ch0 packet waits
    send_pkt(16'h0000, 40);
    send_pkt(16'h0000, 41);
    send_pkt(16'h0001, 42);
    send_pkt(16'h0000, 43);
    repeat (700) @(negedge clk);
    read_pkt(1, 16'h0001, 42, "R8", st);
    check(!ch_empty[0] && ch_empty[1], "R8", "ch0 held, ch1 drained",
          int'(ch_empty[1:0]), 2'b10);
    read_pkt(0, 16'h0000, 40, "R7", st);
    read_pkt(0, 16'h0000, 41, "R7", st);
    read_pkt(0, 16'h0000, 43, "R7", st);
    check(all_empty(), "R7", "no stray words", int'({ch_empty, ctrl_empty}), 5'h1F);
    check(drop_count == 16'(exp_drop), "R4", "drop count final", int'(drop_count), exp_drop);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end
endmodule